// File: doc/BRIEF.md
# Clocked Serial Port with Ready Handshake

This block moves one byte at a time over a three-wire clocked serial link: a shift clock, a data-out line and a data-in line. In master mode it makes the shift clock itself by dividing the system clock. In slave mode it follows a shift clock that arrives from outside. In slave mode it also drives a ready line that tells the remote master the port has been armed by software and is waiting for the first clock edge. The active level of the ready line is programmable.

Software uses four small registers. One sets the enables, the mode and the ready polarity. One holds the trigger bits and reads back as busy flags. One is the data byte. One is the clock divisor. When a transfer completes, a one-cycle interrupt pulse is raised. Transmit and receive can run together as a full-duplex exchange, or either can run alone. Data goes out least significant bit first on the serial output and comes in the same way on the serial input.

Top module: `sync_serial_port`

## Requirements
- R1: With the master bit set, `sclk_oe` is 1 and `sclk_o` idles high. Each transfer produces exactly 8 low-then-high clock periods. Each half period lasts DIV+1 system clocks, where DIV is the divisor register at address 3.
- R2: While a transmit is running, `sdo` carries the data byte least significant bit first, and bit k is stable at the k-th rising shift-clock edge (k from 0). When no transmit is running, `sdo` is 1.
- R3: Receive samples `sdi` on rising shift-clock edges, and the first sampled bit becomes bit 0. The data register at address 2 keeps its old value for the whole transfer and takes the complete byte only at completion.
- R4: `irq` is a single-cycle pulse raised once per transfer after the eighth rising shift-clock edge. It appears in the first cycle in which the data register shows the received byte.
- R5: The trigger register is at address 1. Writing bit 0 starts a transmit and writing bit 1 starts a receive. Reading it returns the transmit busy flag in bit 0 and the receive busy flag in bit 1, and both flags read 0 again in the `irq` cycle.
- R6: The control register is at address 0, with bit 0 as transmit enable, bit 1 as receive enable, bit 2 as master mode and bit 3 as positive ready polarity. A trigger bit written while its enable is 0 has no effect: there is no busy flag, no shift clock and no interrupt.
- R7: In slave mode with positive polarity, `rdy_o` is 1 from the clock edge that accepts a trigger write until the first rising shift-clock edge. At all other times it is 0.
- R8: In slave mode with negative polarity, `rdy_o` is 0 while armed and 1 otherwise. It returns to 1 on the first falling shift-clock edge.
- R9: In master mode `rdy_oe` is 0 and `rdy_o` is 0. In slave mode `rdy_oe` is 1.
- R10: The external shift clock passes through a two-flop synchroniser. A level change on `sclk_i` takes effect on the third system clock edge after it, so the ready line leaves its active level on that edge and not before.
- R11: Trigger writes made while a transfer is in progress are ignored.
- R12: After reset, all control bits are 0 (slave mode, negative polarity), both busy flags and `irq` are 0, and `sclk_o`, `sdo` and `rdy_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data (combinational) |
| irq | output | 1 | Transfer-complete pulse |
| sclk_o | output | 1 | Generated shift clock (master mode) |
| sclk_oe | output | 1 | Shift-clock output enable |
| sclk_i | input | 1 | External shift clock (slave mode) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rdy_o | output | 1 | Ready/busy handshake level |
| rdy_oe | output | 1 | Ready output enable |

## Verification
In master mode the shift engine is driven with a set of vectors that mix divisor values 0 to 5 with full-duplex, transmit-only and receive-only transfers. Byte patterns with single set or clear bits at either end, alternating bits and all-zero or all-one values separate a reversed bit order from a correct one and separate an off-by-one clock count from a correct one. Slave runs cover both ready polarities, so an inverted level or a handshake that drops on the wrong edge shows up. The slave runs also time the ready drop to the exact synchroniser edge. Disabled triggers and triggers written during a transfer are tested to show that they leave the busy flags, the clock and the data register untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TRIG = 2'd1,
    REG_DATA = 2'd2,
    REG_DIV  = 2'd3
  } reg_addr_e;

  localparam int CTL_TXEN   = 0;
  localparam int CTL_RXEN   = 1;
  localparam int CTL_MASTER = 2;
  localparam int CTL_POLPOS = 3;

  localparam int TRG_TX = 0;
  localparam int TRG_RX = 1;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int FRAME_BITS = 8,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int HALVES = 2 * FRAME_BITS;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] H_LAST = HW'(HALVES - 1);

  logic             run_q, run_n;
  logic             sclk_q, sclk_n;
  logic [DIV_W-1:0] dcnt_q, dcnt_n;
  logic [HW-1:0]    hcnt_q, hcnt_n;
  logic             tick;

  assign tick   = run_q && (dcnt_q == div);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_comb begin
    run_n  = run_q;
    sclk_n = sclk_q;
    dcnt_n = dcnt_q;
    hcnt_n = hcnt_q;
    if (start) begin
      run_n  = 1'b1;
      sclk_n = 1'b1;
      dcnt_n = '0;
      hcnt_n = '0;
    end else if (run_q) begin
      if (tick) begin
        dcnt_n = '0;
        sclk_n = !sclk_q;
        if (hcnt_q == H_LAST) begin
          run_n  = 1'b0;
          hcnt_n = '0;
        end else begin
          hcnt_n = hcnt_q + 1'b1;
        end
      end else begin
        dcnt_n = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b1;
      dcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      run_q  <= run_n;
      sclk_q <= sclk_n;
      dcnt_q <= dcnt_n;
      hcnt_q <= hcnt_n;
    end
  end
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 3'b111;
    else        stg_q <= {stg_q[1:0], sclk_i};
  end

  assign rise_o = stg_q[1] && !stg_q[2];
  assign fall_o = !stg_q[1] && stg_q[2];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] load,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  sdi,
  output logic                  sdo_o,
  output logic [FRAME_BITS-1:0] rx_word_o,
  output logic                  done_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] C_LAST = CW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic                  act_q, act_n, done_q, done_n;

  always_comb begin
    tx_n   = tx_q;
    rx_n   = rx_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    done_n = 1'b0;
    if (start) begin
      tx_n  = load;
      cnt_n = '0;
      act_n = 1'b1;
    end else if (act_q) begin
      if (fall && (cnt_q != '0)) tx_n = tx_q >> 1;
      if (rise) begin
        rx_n = {sdi, rx_q[FRAME_BITS-1:1]};
        if (cnt_q == C_LAST) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      done_q <= done_n;
    end
  end

  assign sdo_o     = tx_q[0];
  assign rx_word_o = rx_q;
  assign done_o    = done_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DIV_W      = 8,
  parameter int BUS_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             irq,
  output logic             sclk_o,
  output logic             sclk_oe,
  input  logic             sclk_i,
  output logic             sdo,
  input  logic             sdi,
  output logic             rdy_o,
  output logic             rdy_oe
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic                  tx_en_q, tx_en_n, rx_en_q, rx_en_n;
  logic                  master_q, master_n, pol_q, pol_n;
  logic [DIV_W-1:0]      div_q, div_n;
  logic [FRAME_BITS-1:0] data_q, data_n;
  logic                  tx_busy_q, tx_busy_n, rx_busy_q, rx_busy_n;
  logic                  irq_q, irq_n;
  logic                  seen_q, seen_n;

  logic wr_ctrl, wr_trig, wr_data, wr_div;
  logic xfer_active, tx_go, rx_go, start;
  logic gen_rise, gen_fall, gen_sclk, ext_rise, ext_fall;
  logic sh_rise, sh_fall, sh_done, sh_sdo, first_edge, rdy_active;
  logic [FRAME_BITS-1:0] sh_rx;

  assign wr_ctrl = reg_wr && (reg_addr_e'(reg_addr) == REG_CTRL);
  assign wr_trig = reg_wr && (reg_addr_e'(reg_addr) == REG_TRIG);
  assign wr_data = reg_wr && (reg_addr_e'(reg_addr) == REG_DATA);
  assign wr_div  = reg_wr && (reg_addr_e'(reg_addr) == REG_DIV);

  assign xfer_active = tx_busy_q || rx_busy_q;
  assign tx_go = wr_trig && reg_wdata[TRG_TX] && tx_en_q && !xfer_active;
  assign rx_go = wr_trig && reg_wdata[TRG_RX] && rx_en_q && !xfer_active;
  assign start = tx_go || rx_go;

  ssp_clkgen #(.FRAME_BITS(FRAME_BITS), .DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_q_n), .start(start && master_q), .div(div_q),
    .sclk_o(gen_sclk), .rise_o(gen_rise), .fall_o(gen_fall)
  );

  ssp_edge_sync u_sync (
    .clk(clk), .rst_n(rst_q_n), .sclk_i(sclk_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  assign sh_rise = master_q ? gen_rise : ext_rise;
  assign sh_fall = master_q ? gen_fall : ext_fall;

  ssp_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .start(start), .load(data_q),
    .rise(sh_rise), .fall(sh_fall), .sdi(sdi),
    .sdo_o(sh_sdo), .rx_word_o(sh_rx), .done_o(sh_done)
  );

  assign first_edge = pol_q ? sh_rise : sh_fall;

  always_comb begin
    tx_en_n   = tx_en_q;
    rx_en_n   = rx_en_q;
    master_n  = master_q;
    pol_n     = pol_q;
    div_n     = div_q;
    data_n    = data_q;
    tx_busy_n = tx_busy_q;
    rx_busy_n = rx_busy_q;
    seen_n    = seen_q;
    irq_n     = sh_done;
    if (wr_ctrl) begin
      tx_en_n  = reg_wdata[CTL_TXEN];
      rx_en_n  = reg_wdata[CTL_RXEN];
      master_n = reg_wdata[CTL_MASTER];
      pol_n    = reg_wdata[CTL_POLPOS];
    end
    if (wr_div) div_n = reg_wdata[DIV_W-1:0];
    if (wr_data && !xfer_active) data_n = reg_wdata[FRAME_BITS-1:0];
    if (start) begin
      tx_busy_n = tx_go;
      rx_busy_n = rx_go;
      seen_n    = 1'b0;
    end else if (sh_done) begin
      tx_busy_n = 1'b0;
      rx_busy_n = 1'b0;
      if (rx_busy_q) data_n = sh_rx;
    end else if (xfer_active && first_edge) begin
      seen_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      master_q  <= 1'b0;
      pol_q     <= 1'b0;
      div_q     <= '0;
      data_q    <= '0;
      tx_busy_q <= 1'b0;
      rx_busy_q <= 1'b0;
      irq_q     <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      tx_en_q   <= tx_en_n;
      rx_en_q   <= rx_en_n;
      master_q  <= master_n;
      pol_q     <= pol_n;
      div_q     <= div_n;
      data_q    <= data_n;
      tx_busy_q <= tx_busy_n;
      rx_busy_q <= rx_busy_n;
      irq_q     <= irq_n;
      seen_q    <= seen_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      REG_CTRL: begin
        reg_rdata[CTL_TXEN]   = tx_en_q;
        reg_rdata[CTL_RXEN]   = rx_en_q;
        reg_rdata[CTL_MASTER] = master_q;
        reg_rdata[CTL_POLPOS] = pol_q;
      end
      REG_TRIG: begin
        reg_rdata[TRG_TX] = tx_busy_q;
        reg_rdata[TRG_RX] = rx_busy_q;
      end
      REG_DATA: reg_rdata[FRAME_BITS-1:0] = data_q;
      default:  reg_rdata[DIV_W-1:0] = div_q;
    endcase
  end

  assign rdy_active = !master_q && xfer_active && !seen_q;
  assign rdy_o      = master_q ? 1'b0 : (pol_q ? rdy_active : !rdy_active);
  assign rdy_oe     = !master_q;
  assign sclk_o     = gen_sclk;
  assign sclk_oe    = master_q;
  assign sdo        = tx_busy_q ? sh_sdo : 1'b1;
  assign irq        = irq_q;
endmodule

// File: rtl/ssp_sva.sv
module ssp_sva #(
  parameter int FRAME_BITS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq,
  input logic                  sclk_o,
  input logic                  sclk_oe,
  input logic                  sdo,
  input logic                  rdy_o,
  input logic                  rdy_oe,
  input logic                  master_q,
  input logic                  pol_q,
  input logic                  tx_busy_q,
  input logic                  rx_busy_q,
  input logic [FRAME_BITS-1:0] data_q
);
  a_r4_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r5_busy_clears_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!(tx_busy_q || rx_busy_q) && $past(tx_busy_q || rx_busy_q)));

  a_r3_data_frozen_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy_q && $past(rx_busy_q)) |-> $stable(data_q));

  a_r9_master_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    master_q |-> (!rdy_oe && !rdy_o && sclk_oe));

  a_r1_clock_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && !tx_busy_q && !rx_busy_q) |-> sclk_o);

  a_r7_idle_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && !tx_busy_q && !rx_busy_q) |-> (rdy_o == !pol_q));

  a_r2_sdo_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy_q |-> sdo);
endmodule

bind sync_serial_port ssp_sva #(.FRAME_BITS(FRAME_BITS)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .sdo(sdo), .rdy_o(rdy_o), .rdy_oe(rdy_oe), .master_q(master_q), .pol_q(pol_q),
  .tx_busy_q(tx_busy_q), .rx_busy_q(rx_busy_q), .data_q(data_q)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n, reg_wr, sclk_i, sdi;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, sclk_o, sclk_oe, sdo, rdy_o, rdy_oe;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe)
  );

  // {divisor, tx byte, rx byte, direction: bit0 transmit, bit1 receive}
  localparam logic [25:0] VEC [5] = '{
    {8'd0, 8'hA5, 8'h3C, 2'd3},
    {8'd1, 8'h01, 8'h80, 2'd3},
    {8'd3, 8'hFE, 8'h00, 2'd1},
    {8'd2, 8'h00, 8'hC3, 2'd2},
    {8'd5, 8'h96, 8'h69, 2'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = {24'b0, reg_rdata};
  endtask

  task automatic master_run(input logic [7:0] dv, input logic [7:0] tb,
                            input logic [7:0] rb, input logic [1:0] dir);
    logic [7:0]  got;
    logic [31:0] r;
    int lowbad;
    int w;
    wr_reg(2'd3, dv);
    wr_reg(2'd0, {4'b0, 1'b0, 1'b1, dir[1], dir[0]});
    wr_reg(2'd2, tb);
    sdi = rb[0];
    wr_reg(2'd1, {6'b0, dir});
    rd_now(2'd1, r);
    chk("R5 busy readback after trigger", r, {30'b0, dir});
    got = '0; lowbad = 0;
    for (int k = 0; k < 8; k++) begin
      int lc;
      while (sclk_o !== 1'b0) @(negedge clk);
      sdi = rb[k];
      lc = 0;
      while (sclk_o === 1'b0) begin lc++; @(negedge clk); end
      if (lc != int'(dv) + 1) lowbad++;
      got[k] = sdo;
    end
    chk("R1 low half periods of wrong length", lowbad, 0);
    if (dir[0]) chk("R2 master bits on sdo, lsb first", got, tb);
    w = 0;
    while (irq !== 1'b1 && w < 8) begin w++; @(negedge clk); end
    chk("R4 irq after eighth bit", irq, 1);
    rd_now(2'd2, r);
    chk("R3 data register at completion", r, dir[1] ? rb : tb);
    @(negedge clk);
    chk("R4 irq lasts one cycle", irq, 0);
    rd_now(2'd1, r);
    chk("R5 busy cleared", r, 0);
    chk("R1 shift clock idles high", sclk_o, 1);
  endtask

  task automatic slave_run(input logic pol, input logic [7:0] tb,
                           input logic [7:0] rb, input logic [1:0] dir);
    logic [7:0]  got;
    logic [31:0] r;
    string       tg;
    int          w;
    tg = pol ? "R7" : "R8";
    sclk_i = 1'b1;
    wr_reg(2'd0, {4'b0, pol, 1'b0, dir[1], dir[0]});
    wr_reg(2'd2, tb);
    chk($sformatf("%s ready at busy level before arming", tg), rdy_o, !pol);
    chk("R9 ready driven in slave mode", rdy_oe, 1);
    chk("R2 sdo high before transfer", sdo, 1);
    wr_reg(2'd1, {6'b0, dir});
    chk($sformatf("%s ready active once armed", tg), rdy_o, pol);
    got = '0;
    for (int k = 0; k < 8; k++) begin
      sclk_i = 1'b0;
      sdi = rb[k];
      if (k == 0 && !pol) begin
        @(negedge clk); @(negedge clk);
        chk("R10 ready held for two edges after falling shift clock", rdy_o, 0);
        @(negedge clk);
        chk("R8 ready back to 1 on first falling edge", rdy_o, 1);
        @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
      if (k == 0 && pol) chk("R7 ready stays high through falling edge", rdy_o, 1);
      got[k] = sdo;
      if (k == 4) begin
        rd_now(2'd2, r);
        chk("R3 data register unchanged mid-frame", r, tb);
      end
      sclk_i = 1'b1;
      if (k == 0 && pol) begin
        @(negedge clk); @(negedge clk);
        chk("R10 ready held for two edges after rising shift clock", rdy_o, 1);
        @(negedge clk);
        chk("R7 ready drops on first rising edge", rdy_o, 0);
        @(negedge clk);
      end else if (k < 7) begin
        repeat (4) @(negedge clk);
      end
    end
    w = 0;
    while (irq !== 1'b1 && w < 10) begin w++; @(negedge clk); end
    chk("R4 slave irq after eighth bit", irq, 1);
    rd_now(2'd2, r);
    chk("R3 slave data register at completion", r, dir[1] ? rb : tb);
    if (dir[0]) chk("R2 slave bits on sdo, lsb first", got, tb);
    @(negedge clk);
    chk("R4 slave irq lasts one cycle", irq, 0);
    chk($sformatf("%s ready at busy level after transfer", tg), rdy_o, !pol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int hi;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    sclk_i = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd_now(2'd0, r); chk("R12 control register after reset", r, 0);
    rd_now(2'd1, r); chk("R12 busy flags after reset", r, 0);
    chk("R12 irq after reset", irq, 0);
    chk("R12 sclk_o after reset", sclk_o, 1);
    chk("R12 sdo after reset", sdo, 1);
    chk("R12 rdy_o busy level after reset", rdy_o, 1);
    chk("R9 slave after reset drives ready", rdy_oe, 1);

    for (int i = 0; i < 5; i++)
      master_run(VEC[i][25:18], VEC[i][17:10], VEC[i][9:2], VEC[i][1:0]);

    // R6: triggers with enables cleared
    wr_reg(2'd0, 8'b0000_0100);
    chk("R9 master: ready not driven", rdy_oe, 0);
    chk("R9 master: ready low", rdy_o, 0);
    chk("R1 master drives clock", sclk_oe, 1);
    wr_reg(2'd1, 8'h03);
    rd_now(2'd1, r);
    chk("R6 disabled trigger leaves busy clear", r, 0);
    hi = 1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (sclk_o !== 1'b1 || irq !== 1'b0) hi = 0;
    end
    chk("R6 disabled trigger produces no clock or irq", hi, 1);

    // R11: receive trigger during an active transmit
    sdi = 1'b0;
    wr_reg(2'd3, 8'd2);
    wr_reg(2'd0, 8'b0000_0111);
    wr_reg(2'd2, 8'h5A);
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd1, 8'h02);
    rd_now(2'd1, r);
    chk("R11 trigger during transfer ignored", r, 1);
    hi = 0;
    while (irq !== 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    rd_now(2'd2, r);
    chk("R11 ignored receive did not capture", r, 8'h5A);
    @(negedge clk);

    slave_run(1'b1, 8'hB4, 8'h2D, 2'd3);
    slave_run(1'b0, 8'h0F, 8'hE1, 2'd2);
    slave_run(1'b0, 8'h81, 8'h00, 2'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule